// File: doc/BRIEF.md
# Time Base and Watchdog Unit

This block turns a 32.768 kHz system clock into two kinds of host alert that share a single active-low interrupt line. A divide-by-256 prescaler produces a 128 Hz tick, and a further binary divider chain derives slower rates from it. A 3-bit rate code picks one tap of that chain. The tap drives a square wave on the interrupt line when the timer output is on. The same tap also clocks a divide-by-4 watchdog stage. If the host does not clear the watchdog in time, a timeout flag is latched and holds the line low.

A command decoder outside the block supplies single-cycle strobes: timer on, off and clear; watchdog on, off and clear; IRQ on and off; and a rate load that takes the 3-bit code. The three enables are independent of each other. When the IRQ output is off, the line idles high. When the watchdog is on, the line shows its flag. Otherwise, when the timer is on, the line shows the square wave. A system enable input stops all counting and holds every stage at zero while it is low. The interrupt output is registered, so each change appears one clock after its cause.

Top module: `twd_unit`

## Requirements
- R1: After reset, timer output, watchdog and IRQ output are all off, the rate code is 000, and `irq_n` is high. While either IRQ or the source feeding it is still off by default, `irq_n` stays high.
- R2: With IRQ and timer on, watchdog off, and rate code c, `irq_n` is a square wave with a period of 2^(PRESCALE_BITS+7-c) clocks. Following a timer clear, it is high for the first half-period and low for the second, delayed by one clock. Code 000 gives the slowest rate (1 Hz at default parameters) and code 111 gives the fastest (128 Hz).
- R3: With the watchdog on, a timer clear and a watchdog clear issued in the same cycle start a timeout of exactly four selected periods. The flag sets on the 4·T-th clock edge after the clear, and `irq_n` goes low on the following edge.
- R4: Once set, the timeout flag keeps `irq_n` low across any number of further periods. While the watchdog is on, it takes precedence over the timer square wave.
- R5: A watchdog clear resets the divide-by-4 stage and the flag in the same cycle. `irq_n` returns high one clock later.
- R6: An IRQ-off strobe forces `irq_n` high one clock later and discards a latched timeout flag. Turning IRQ back on therefore does not bring back the old timeout.
- R7: A timer clear zeroes the shared prescaler and divider chain, which restarts the square-wave phase. A rate load takes effect in the cycle after its strobe.
- R8: While the watchdog is off, its divide-by-4 stage holds its value and no timeout can occur. Turning it back on later resumes counting from the held value.
- R9: While `sys_en` is low, the chain, the watchdog stage and the flag are held at zero and `irq_n` is high. Counting resumes from zero on the first clock with `sys_en` high.
- R10: When an on strobe and an off strobe for the same control arrive in one cycle, the off strobe wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_en | input | 1 | High lets the chain count; low holds every stage at zero |
| tmr_en_s | input | 1 | Strobe: timer output on |
| tmr_dis_s | input | 1 | Strobe: timer output off |
| tmr_clr_s | input | 1 | Strobe: zero the prescaler and divider chain |
| wdt_en_s | input | 1 | Strobe: watchdog on |
| wdt_dis_s | input | 1 | Strobe: watchdog off |
| wdt_clr_s | input | 1 | Strobe: zero the watchdog stage and flag |
| irq_en_s | input | 1 | Strobe: IRQ output on |
| irq_dis_s | input | 1 | Strobe: IRQ output off and flag discard |
| rate_ld_s | input | 1 | Strobe: load `rate_code` |
| rate_code | input | 3 | Rate code, 000 slowest to 111 fastest |
| irq_n | output | 1 | Registered active-low interrupt, idles high |

## Verification
The square wave is tried at four rate codes: the default 000, plus 011, 101 and 111. Comparing edge by edge after a timer clear separates a wrong tap from a wrong phase or an extra register stage. Watchdog timeouts are timed at two codes, each from a joint clear. Sampling the clock before and after the expected edge catches an off-by-one in the divide-by-4 stage. A timeout started after a long disabled interval tells a frozen stage apart from one that kept counting. Latch, clear, IRQ-off, system-off and same-cycle on/off patterns each show whether the flag and the enables obey their precedence.

// File: rtl/twd_pkg.sv
package twd_pkg;

    // Width of the rate code and the number of divider steps it spans.
    localparam int RATE_W = 3;
    localparam int STEPS  = (2 ** RATE_W) - 1;
    // Watchdog divide-by-4 stage width.
    localparam int WDT_W  = 2;

    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [WDT_W-1:0]  wstage_t;

    typedef struct packed {
        logic tmr_on;
        logic wdt_on;
        logic irq_on;
    } twd_mode_t;

    // The chain bit that carries the selected square wave.
    function automatic int tap_of(input int cnt_w, input rate_t code);
        return cnt_w - 1 - int'(code);
    endfunction

    // Level the interrupt line should take next.
    function automatic logic irq_level(input twd_mode_t m, input logic flag,
                                       input logic sq);
        logic lvl;
        if (!m.irq_on)      lvl = 1'b1;
        else if (m.wdt_on)  lvl = ~flag;
        else if (m.tmr_on)  lvl = ~sq;
        else                lvl = 1'b1;
        return lvl;
    endfunction

endpackage

// File: rtl/twd_ctrl.sv
module twd_ctrl
    import twd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tmr_en_s,
    input  logic      tmr_dis_s,
    input  logic      wdt_en_s,
    input  logic      wdt_dis_s,
    input  logic      irq_en_s,
    input  logic      irq_dis_s,
    input  logic      rate_ld_s,
    input  rate_t     rate_code,
    output twd_mode_t mode,
    output rate_t     rate
);

    // Off strobes are applied last, so they win over a same-cycle on strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
            rate <= '0;
        end else begin
            if (tmr_en_s)  mode.tmr_on <= 1'b1;
            if (tmr_dis_s) mode.tmr_on <= 1'b0;
            if (wdt_en_s)  mode.wdt_on <= 1'b1;
            if (wdt_dis_s) mode.wdt_on <= 1'b0;
            if (irq_en_s)  mode.irq_on <= 1'b1;
            if (irq_dis_s) mode.irq_on <= 1'b0;
            if (rate_ld_s) rate <= rate_code;
        end
    end

endmodule

// File: rtl/twd_chain.sv
module twd_chain
    import twd_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sys_en,
    input  logic                    tmr_clr,
    input  rate_t                   rate,
    output logic                    sq,
    output logic                    wrap,
    output logic [PRE_W+STEPS-1:0]  cnt
);

    localparam int CNT_W = PRE_W + STEPS;
    localparam int TAP_W = $clog2(CNT_W);

    logic [TAP_W-1:0] tap;
    logic [CNT_W-1:0] mask;

    // Prescaler and divider chain form one binary counter.
    always_ff @(posedge clk) begin
        if (rst || !sys_en || tmr_clr) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    always_comb begin
        tap = TAP_W'(tap_of(CNT_W, rate));
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (i <= int'(tap));
        end
        sq   = cnt[tap];
        // End of one selected period: every bit up to the tap is one.
        wrap = sys_en && !tmr_clr && ((cnt & mask) == mask);
    end

endmodule

// File: rtl/twd_wdog.sv
module twd_wdog
    import twd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sys_en,
    input  logic    wdt_on,
    input  logic    wdt_clr,
    input  logic    irq_dis,
    input  logic    wrap,
    output wstage_t stage,
    output logic    flag
);

    always_ff @(posedge clk) begin
        if (rst || !sys_en || wdt_clr) begin
            stage <= '0;
            flag  <= 1'b0;
        end else begin
            if (wdt_on && wrap) begin
                stage <= stage + 1'b1;
                if (stage == '1) flag <= 1'b1;
            end
            if (irq_dis) flag <= 1'b0;
        end
    end

endmodule

// File: rtl/twd_irq_out.sv
module twd_irq_out
    import twd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  twd_mode_t mode,
    input  logic      flag,
    input  logic      sq,
    output logic      irq_n
);

    always_ff @(posedge clk) begin
        if (rst) irq_n <= 1'b1;
        else     irq_n <= irq_level(mode, flag, sq);
    end

endmodule

// File: rtl/twd_unit.sv
module twd_unit
    import twd_pkg::*;
#(
    parameter int PRESCALE_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_en,
    input  logic              tmr_en_s,
    input  logic              tmr_dis_s,
    input  logic              tmr_clr_s,
    input  logic              wdt_en_s,
    input  logic              wdt_dis_s,
    input  logic              wdt_clr_s,
    input  logic              irq_en_s,
    input  logic              irq_dis_s,
    input  logic              rate_ld_s,
    input  logic [RATE_W-1:0] rate_code,
    output logic              irq_n
);

    localparam int CNT_W = PRESCALE_BITS + STEPS;

    twd_mode_t        mode;
    rate_t            rate;
    logic             tb_sq;
    logic             tb_wrap;
    logic [CNT_W-1:0] tb_cnt;
    wstage_t          wdt_stage;
    logic             wdt_flag;

    twd_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tmr_en_s  (tmr_en_s),
        .tmr_dis_s (tmr_dis_s),
        .wdt_en_s  (wdt_en_s),
        .wdt_dis_s (wdt_dis_s),
        .irq_en_s  (irq_en_s),
        .irq_dis_s (irq_dis_s),
        .rate_ld_s (rate_ld_s),
        .rate_code (rate_code),
        .mode      (mode),
        .rate      (rate)
    );

    twd_chain #(.PRE_W(PRESCALE_BITS)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .sys_en  (sys_en),
        .tmr_clr (tmr_clr_s),
        .rate    (rate),
        .sq      (tb_sq),
        .wrap    (tb_wrap),
        .cnt     (tb_cnt)
    );

    twd_wdog u_wdog (
        .clk     (clk),
        .rst     (rst),
        .sys_en  (sys_en),
        .wdt_on  (mode.wdt_on),
        .wdt_clr (wdt_clr_s),
        .irq_dis (irq_dis_s),
        .wrap    (tb_wrap),
        .stage   (wdt_stage),
        .flag    (wdt_flag)
    );

    twd_irq_out u_out (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .flag  (wdt_flag),
        .sq    (tb_sq),
        .irq_n (irq_n)
    );

endmodule

// File: rtl/twd_unit_chk.sv
module twd_unit_chk
    import twd_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             sys_en,
    input logic             wdt_clr_s,
    input logic             irq_dis_s,
    input logic             irq_n,
    input logic             wdt_on,
    input logic             wdt_flag,
    input wstage_t          wdt_stage,
    input logic [CNT_W-1:0] tb_cnt
);

    // R1: reset releases the line
    a_r1_reset_high: assert property (@(posedge clk) rst |=> irq_n);

    // R3: the flag rises only as the divide-by-4 stage rolls over
    a_r3_flag_on_rollover: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_flag) |-> ($past(wdt_stage) == '1 && wdt_stage == '0));

    // R4: a latched flag holds without a clear, an IRQ-off or a system-off
    a_r4_flag_hold: assert property (@(posedge clk) disable iff (rst)
        (wdt_flag && !wdt_clr_s && !irq_dis_s && sys_en) |=> wdt_flag);

    // R5: watchdog clear drops the flag at once
    a_r5_clr_drops_flag: assert property (@(posedge clk) disable iff (rst)
        wdt_clr_s |=> !wdt_flag);

    // R6: IRQ-off releases the line two edges later
    a_r6_irq_off_high: assert property (@(posedge clk) disable iff (rst)
        irq_dis_s |=> ##1 irq_n);

    // R8: a disabled watchdog keeps its stage
    a_r8_stage_frozen: assert property (@(posedge clk) disable iff (rst)
        (sys_en && !wdt_on && !wdt_clr_s) |=> $stable(wdt_stage));

    // R9: system-off zeroes every stage
    a_r9_sys_off_zero: assert property (@(posedge clk) disable iff (rst)
        !sys_en |=> (tb_cnt == '0 && wdt_stage == '0 && !wdt_flag));

endmodule

bind twd_unit twd_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sys_en    (sys_en),
    .wdt_clr_s (wdt_clr_s),
    .irq_dis_s (irq_dis_s),
    .irq_n     (irq_n),
    .wdt_on    (mode.wdt_on),
    .wdt_flag  (wdt_flag),
    .wdt_stage (wdt_stage),
    .tb_cnt    (tb_cnt)
);

// File: tb/tb_twd_unit.sv
module tb_twd_unit;

    localparam int CLK_PERIOD = 10;
    localparam int PRE        = 4;
    localparam int TOPBIT     = PRE + 6;

    localparam logic [8:0] C_TEN  = 9'h001;
    localparam logic [8:0] C_TDIS = 9'h002;
    localparam logic [8:0] C_TCLR = 9'h004;
    localparam logic [8:0] C_WEN  = 9'h008;
    localparam logic [8:0] C_WDIS = 9'h010;
    localparam logic [8:0] C_WCLR = 9'h020;
    localparam logic [8:0] C_IEN  = 9'h040;
    localparam logic [8:0] C_IDIS = 9'h080;
    localparam logic [8:0] C_RLD  = 9'h100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sys_en = 1'b1;
    logic tmr_en_s = 0, tmr_dis_s = 0, tmr_clr_s = 0;
    logic wdt_en_s = 0, wdt_dis_s = 0, wdt_clr_s = 0;
    logic irq_en_s = 0, irq_dis_s = 0, rate_ld_s = 0;
    logic [2:0] rate_code = 3'd0;
    logic irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twd_unit #(.PRESCALE_BITS(PRE)) dut (
        .clk(clk), .rst(rst), .sys_en(sys_en),
        .tmr_en_s(tmr_en_s), .tmr_dis_s(tmr_dis_s), .tmr_clr_s(tmr_clr_s),
        .wdt_en_s(wdt_en_s), .wdt_dis_s(wdt_dis_s), .wdt_clr_s(wdt_clr_s),
        .irq_en_s(irq_en_s), .irq_dis_s(irq_dis_s), .rate_ld_s(rate_ld_s),
        .rate_code(rate_code), .irq_n(irq_n)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: irq_n actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle of strobes; returns just after the edge that took them.
    task automatic cmd(input logic [8:0] v, input logic [2:0] code);
        {rate_ld_s, irq_dis_s, irq_en_s, wdt_clr_s, wdt_dis_s,
         wdt_en_s, tmr_clr_s, tmr_dis_s, tmr_en_s} = v;
        rate_code = code;
        step();
        {rate_ld_s, irq_dis_s, irq_en_s, wdt_clr_s, wdt_dis_s,
         wdt_en_s, tmr_clr_s, tmr_dis_s, tmr_en_s} = '0;
    endtask

    function automatic logic bitk(input int v, input int k);
        return logic'((v >> k) & 1);
    endfunction

    function automatic int period_of(input int code);
        return 1 << (TOPBIT + 1 - code);
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        check("R1 reset level", irq_n, 1'b1);
    endtask

    task automatic t_defaults();
        cmd(C_TCLR | C_RLD, 3'd7);
        for (int j = 0; j < 40; j++) begin
            step();
            check("R1 irq off by default", irq_n, 1'b1);
        end
        cmd(C_IEN, 3'd0);
        for (int j = 0; j < 40; j++) begin
            step();
            check("R1 timer and watchdog off by default", irq_n, 1'b1);
        end
    endtask

    task automatic t_default_rate();
        cmd(C_RLD, 3'd0);
        cmd(C_TEN, 3'd0);
        cmd(C_TCLR, 3'd0);
        repeat (1024) step();
        check("R2 code 000 first half high", irq_n, 1'b1);
        step();
        check("R2 code 000 second half low", irq_n, 1'b0);
    endtask

    task automatic t_square(input int code);
        int p = period_of(code);
        cmd(C_TCLR | C_RLD, 3'(code));
        step();
        for (int j = 2; j <= 2 * p + 1; j++) begin
            step();
            check($sformatf("R2 R7 square code %0d", code), irq_n,
                  ~bitk(j - 1, TOPBIT - code));
        end
    endtask

    task automatic t_wdt_timeout(input int code);
        int p = period_of(code);
        cmd(C_WEN, 3'd0);
        cmd(C_TCLR | C_WCLR | C_RLD, 3'(code));
        for (int j = 1; j <= 4 * p; j++) begin
            step();
            check($sformatf("R3 R4 no timeout yet code %0d", code), irq_n, 1'b1);
        end
        step();
        check($sformatf("R3 timeout code %0d", code), irq_n, 1'b0);
    endtask

    task automatic t_latch_and_clear();
        repeat (3 * period_of(7)) step();
        check("R4 flag stays latched", irq_n, 1'b0);
        cmd(C_WCLR, 3'd0);
        step();
        check("R5 watchdog clear releases", irq_n, 1'b1);
    endtask

    task automatic t_irq_off();
        cmd(C_IDIS, 3'd0);
        step();
        check("R6 irq off releases", irq_n, 1'b1);
        cmd(C_IEN, 3'd0);
        step();
        step();
        check("R6 old flag discarded", irq_n, 1'b1);
    endtask

    task automatic t_wdt_off();
        int p = period_of(7);
        cmd(C_TDIS, 3'd0);
        cmd(C_TCLR | C_WCLR | C_RLD, 3'd7);
        cmd(C_WDIS, 3'd0);
        repeat (10 * p) step();
        check("R8 disabled watchdog silent", irq_n, 1'b1);
        cmd(C_WEN | C_TCLR, 3'd0);
        repeat (4 * p) step();
        check("R8 stage held, not yet", irq_n, 1'b1);
        step();
        check("R8 stage held, timeout", irq_n, 1'b0);
    endtask

    task automatic t_sys_off();
        int p = period_of(7);
        cmd(C_WDIS | C_TEN, 3'd0);
        repeat (5) step();
        sys_en = 1'b0;
        step();
        for (int j = 0; j < 19; j++) begin
            step();
            check("R9 held while off", irq_n, 1'b1);
        end
        sys_en = 1'b1;
        for (int m = 0; m < 32; m++) begin
            step();
            check("R9 restart from zero", irq_n, ~bitk(m, TOPBIT - 7));
        end
        cmd(C_WEN | C_WCLR | C_TCLR, 3'd0);
        repeat (4 * p + 1) step();
        check("R9 setup timeout", irq_n, 1'b0);
        sys_en = 1'b0;
        step();
        step();
        check("R9 system off clears flag", irq_n, 1'b1);
        sys_en = 1'b1;
        step();
        check("R9 flag stays cleared", irq_n, 1'b1);
    endtask

    task automatic t_priority();
        cmd(C_WDIS, 3'd0);
        cmd(C_TEN | C_TDIS, 3'd0);
        step();
        for (int j = 0; j < 32; j++) begin
            step();
            check("R10 timer off wins", irq_n, 1'b1);
        end
        cmd(C_TEN, 3'd0);
        cmd(C_IEN | C_IDIS, 3'd0);
        step();
        for (int j = 0; j < 32; j++) begin
            step();
            check("R10 irq off wins", irq_n, 1'b1);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_defaults();
        t_default_rate();
        t_square(7);
        t_square(5);
        t_square(3);
        t_wdt_timeout(7);
        t_latch_and_clear();
        t_wdt_timeout(6);
        t_irq_off();
        t_wdt_off();
        t_sys_off();
        t_priority();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule